// File: doc/BRIEF.md
# Kernel Control Register Slave

This block sits between a host-facing AXI4-Lite port and a compute kernel. It gives the host a small window of 32-bit words: one word to launch the kernel and poll for completion, a run of parameter words the kernel reads, and a run of result words the kernel fills in when it is done. The kernel sees a one-cycle launch pulse and a flat vector of all parameter words. When it is done, it raises a finish strobe for one cycle together with a flat vector of result values.

The host writes parameters, writes the launch code to the control word, then polls the control word until it reads the completion code, and finally reads the result words. Only one bus transaction per direction is in progress at a time. The write address and write data may arrive in any order. Both responses are held until the host takes them.

Top module: `kctl_lite_slave`

## Requirements
- R1: The word index is address bits [ADDR_W-1:2], and address bits [1:0] are ignored. Index 0 is the control word. Parameter k is at index 4+k (byte offset 0x010+4k). Result j is at index 4+N_IN+j, directly after the last parameter.
- R2: A committed write of 0x00000001 to index 0 with all four strobes set, while the kernel is not running, launches the kernel. k_start is high for exactly one cycle, the same cycle BVALID first rises for that write. While the kernel is running, the control word reads 0x00000000.
- R3: A finish strobe while running loads every result word in that one cycle: result j takes k_results bits [32j+31:32j]. From then on the control word reads 0x00000004 until the next launch.
- R4: Parameter words are written with per-byte strobes; byte b takes wdata[8b+7:8b] only when wstrb[b]=1. Parameter k drives k_params bits [32k+31:32k] and reads back its stored value. It changes only in the cycle BVALID rises for a write to it.
- R5: Writes to result words, to unmapped indices, and any control write other than the launch case change no state, and each is answered with a write response.
- R6: Reads of unmapped indices (1 to 3, and index 4+N_IN+N_OUT and above) return 0. Every response, read or write, carries the OKAY code 2'b00.
- R7: Write address and write data may be accepted in the same cycle or in either order. The write takes effect only after both are accepted, and AWREADY (or WREADY) stays low while its own item is held.
- R8: BVALID stays high until BREADY. RVALID stays high, with RDATA unchanged, until RREADY.
- R9: While rst_n is low at a clock edge, all of the following are cleared: the kernel returns to idle (control reads 0), every parameter and result word is set to 0, BVALID and RVALID go low, and k_start goes low.
- R10: A finish strobe while not running is ignored. A launch write while running produces no k_start and leaves the kernel running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_awaddr | input | ADDR_W | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response code |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response code |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| k_start | output | 1 | One-cycle launch pulse to the kernel |
| k_params | output | 32*N_IN | All parameter words, word k at bits [32k+31:32k] |
| k_finish | input | 1 | Kernel completion strobe |
| k_results | input | 32*N_OUT | Result values loaded on finish |

## Verification
The bench builds the block with N_IN=3, N_OUT=2 and ADDR_W=8. The result words then sit at 0x01C and 0x020, and the first unmapped word after them is 0x024. The address space is small enough for the bench to probe the gap at 0x004, the word just past the results, and the top word 0x0FC. Three parameters are enough to drive each write ordering at a different word. Two results show that the finish vector is split into words in the right order.

// File: rtl/kctl_pkg.sv
// Shared definitions for the kernel control slave.
// Assumes 32-bit data words and byte strobes on the bus side.
package kctl_pkg;
    localparam int WORD_W          = 32;
    localparam int STRB_W          = WORD_W / 8;
    localparam int PARAM_BASE_IDX  = 4;
    localparam logic [WORD_W-1:0] LAUNCH_CODE = 32'h0000_0001;
    localparam logic [WORD_W-1:0] DONE_CODE   = 32'h0000_0004;
    localparam logic [1:0] RESP_OKAY = 2'b00;

    typedef enum logic [1:0] {
        KS_IDLE = 2'd0,
        KS_RUN  = 2'd1,
        KS_DONE = 2'd2
    } kstate_t;

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic [STRB_W-1:0] strb;
    } wbeat_t;
endpackage

// File: rtl/kctl_wr_chan.sv
// Write side of the AXI4-Lite port. Holds the address and the data beat
// separately, so they can come in either order. Commits one write once
// both are held and no response is pending. Assumes a single outstanding write.
module kctl_wr_chan
    import kctl_pkg::*;
#(
    parameter int ADDR_W = 12,
    localparam int IDX_W = ADDR_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] awaddr,
    input  logic              awvalid,
    output logic              awready,
    input  logic [WORD_W-1:0] wdata,
    input  logic [STRB_W-1:0] wstrb,
    input  logic              wvalid,
    output logic              wready,
    output logic [1:0]        bresp,
    output logic              bvalid,
    input  logic              bready,
    output logic              commit,
    output logic [IDX_W-1:0]  commit_idx,
    output wbeat_t            commit_beat
);
    logic             aw_held;
    logic             w_held;
    logic             bvalid_q;
    logic [IDX_W-1:0] idx_q;
    wbeat_t           beat_q;
    logic             unused_low_addr;

    assign unused_low_addr = ^awaddr[1:0];
    assign awready     = !aw_held;
    assign wready      = !w_held;
    assign commit      = aw_held && w_held && !bvalid_q;
    assign commit_idx  = idx_q;
    assign commit_beat = beat_q;
    assign bvalid      = bvalid_q;
    assign bresp       = RESP_OKAY;

    // Capture address and data, release both on commit, manage the response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aw_held  <= 1'b0;
            w_held   <= 1'b0;
            bvalid_q <= 1'b0;
            idx_q    <= '0;
            beat_q   <= '0;
        end else begin
            if (commit) begin
                aw_held  <= 1'b0;
                w_held   <= 1'b0;
                bvalid_q <= 1'b1;
            end else begin
                if (awvalid && !aw_held) begin
                    aw_held <= 1'b1;
                    idx_q   <= awaddr[ADDR_W-1:2];
                end
                if (wvalid && !w_held) begin
                    w_held      <= 1'b1;
                    beat_q.data <= wdata;
                    beat_q.strb <= wstrb;
                end
                if (bvalid_q && bready) begin
                    bvalid_q <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/kctl_rd_chan.sv
// Read side of the AXI4-Lite port. It accepts an address only when no read
// data is pending. It captures the register file's read value in the
// accepting cycle and holds it until the host takes it.
module kctl_rd_chan
    import kctl_pkg::*;
#(
    parameter int ADDR_W = 12,
    localparam int IDX_W = ADDR_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] araddr,
    input  logic              arvalid,
    output logic              arready,
    output logic [WORD_W-1:0] rdata,
    output logic [1:0]        rresp,
    output logic              rvalid,
    input  logic              rready,
    output logic [IDX_W-1:0]  look_idx,
    input  logic [WORD_W-1:0] look_data
);
    logic              rvalid_q;
    logic [WORD_W-1:0] rdata_q;
    logic              unused_low_addr;

    assign unused_low_addr = ^araddr[1:0];
    assign arready  = !rvalid_q;
    assign look_idx = araddr[ADDR_W-1:2];
    assign rvalid   = rvalid_q;
    assign rdata    = rdata_q;
    assign rresp    = RESP_OKAY;

    // Load the read value on address acceptance, drop valid on handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid_q <= 1'b0;
            rdata_q  <= '0;
        end else if (arvalid && !rvalid_q) begin
            rvalid_q <= 1'b1;
            rdata_q  <= look_data;
        end else if (rvalid_q && rready) begin
            rvalid_q <= 1'b0;
        end
    end
endmodule

// File: rtl/kctl_regfile.sv
// Register words and the kernel run state. It decodes committed writes
// into parameter and control updates, loads result words on finish, and
// serves a combinational read port. Assumes N_IN >= 1 and N_OUT >= 1.
module kctl_regfile
    import kctl_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int N_IN   = 2,
    parameter int N_OUT  = 1,
    localparam int IDX_W  = ADDR_W - 2,
    localparam int OUT_LO = PARAM_BASE_IDX + N_IN,
    localparam int OUT_HI = OUT_LO + N_OUT
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_idx,
    input  wbeat_t                  wr_beat,
    input  logic [IDX_W-1:0]        rd_idx,
    output logic [WORD_W-1:0]       rd_data,
    output logic                    k_start,
    output logic [N_IN*WORD_W-1:0]  k_params,
    input  logic                    k_finish,
    input  logic [N_OUT*WORD_W-1:0] k_results
);
    kstate_t                  state_q;
    logic                     start_q;
    logic                     launch_hit;
    logic [N_OUT*WORD_W-1:0]  result_q;
    logic [N_IN*WORD_W-1:0]   param_flat;

    assign launch_hit = wr_en && (wr_idx == '0) && (wr_beat.strb == '1)
                        && (wr_beat.data == LAUNCH_CODE) && (state_q != KS_RUN);

    // Run state: launch from idle or done, complete on finish while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= KS_IDLE;
            start_q <= 1'b0;
        end else begin
            start_q <= launch_hit;
            if (launch_hit) begin
                state_q <= KS_RUN;
            end else if (k_finish && state_q == KS_RUN) begin
                state_q <= KS_DONE;
            end
        end
    end

    // Result words load together on a finish strobe while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
        end else if (k_finish && state_q == KS_RUN) begin
            result_q <= k_results;
        end
    end

    // One parameter word per block, each with byte-strobed writes.
    for (genvar k = 0; k < N_IN; k++) begin : g_param
        logic [WORD_W-1:0] word_q;
        logic              hit;
        assign hit = wr_en && (int'(wr_idx) == PARAM_BASE_IDX + k);
        // Merge the strobed bytes of a committed write into this word.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (hit) begin
                for (int b = 0; b < STRB_W; b++) begin
                    if (wr_beat.strb[b]) begin
                        word_q[8*b +: 8] <= wr_beat.data[8*b +: 8];
                    end
                end
            end
        end
        assign param_flat[WORD_W*k +: WORD_W] = word_q;
    end

    assign k_params = param_flat;
    assign k_start  = start_q;

    // Read mux: control code, parameters, results, zero elsewhere.
    always_comb begin
        rd_data = '0;
        if (rd_idx == '0) begin
            rd_data = (state_q == KS_DONE) ? DONE_CODE : '0;
        end
        for (int k = 0; k < N_IN; k++) begin
            if (int'(rd_idx) == PARAM_BASE_IDX + k) begin
                rd_data = param_flat[WORD_W*k +: WORD_W];
            end
        end
        for (int j = 0; j < N_OUT; j++) begin
            if (int'(rd_idx) == OUT_LO + j) begin
                rd_data = result_q[WORD_W*j +: WORD_W];
            end
        end
    end

    logic unused_hi;
    assign unused_hi = (OUT_HI > 0);
endmodule

// File: rtl/kctl_lite_slave.sv
// Top of the kernel control slave: joins the write channel, the read
// channel and the register file. Assumes one bus clock shared with the
// kernel and a synchronous active-low reset.
module kctl_lite_slave
    import kctl_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int N_IN   = 2,
    parameter int N_OUT  = 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       s_awaddr,
    input  logic                    s_awvalid,
    output logic                    s_awready,
    input  logic [31:0]             s_wdata,
    input  logic [3:0]              s_wstrb,
    input  logic                    s_wvalid,
    output logic                    s_wready,
    output logic [1:0]              s_bresp,
    output logic                    s_bvalid,
    input  logic                    s_bready,
    input  logic [ADDR_W-1:0]       s_araddr,
    input  logic                    s_arvalid,
    output logic                    s_arready,
    output logic [31:0]             s_rdata,
    output logic [1:0]              s_rresp,
    output logic                    s_rvalid,
    input  logic                    s_rready,
    output logic                    k_start,
    output logic [N_IN*32-1:0]      k_params,
    input  logic                    k_finish,
    input  logic [N_OUT*32-1:0]     k_results
);
    localparam int IDX_W = ADDR_W - 2;

    logic             commit;
    logic [IDX_W-1:0] commit_idx;
    wbeat_t           commit_beat;
    logic [IDX_W-1:0] look_idx;
    logic [31:0]      look_data;

    kctl_wr_chan #(.ADDR_W(ADDR_W)) u_wr (
        .clk(clk), .rst_n(rst_n),
        .awaddr(s_awaddr), .awvalid(s_awvalid), .awready(s_awready),
        .wdata(s_wdata), .wstrb(s_wstrb), .wvalid(s_wvalid), .wready(s_wready),
        .bresp(s_bresp), .bvalid(s_bvalid), .bready(s_bready),
        .commit(commit), .commit_idx(commit_idx), .commit_beat(commit_beat)
    );

    kctl_rd_chan #(.ADDR_W(ADDR_W)) u_rd (
        .clk(clk), .rst_n(rst_n),
        .araddr(s_araddr), .arvalid(s_arvalid), .arready(s_arready),
        .rdata(s_rdata), .rresp(s_rresp), .rvalid(s_rvalid), .rready(s_rready),
        .look_idx(look_idx), .look_data(look_data)
    );

    kctl_regfile #(.ADDR_W(ADDR_W), .N_IN(N_IN), .N_OUT(N_OUT)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(commit), .wr_idx(commit_idx), .wr_beat(commit_beat),
        .rd_idx(look_idx), .rd_data(look_data),
        .k_start(k_start), .k_params(k_params),
        .k_finish(k_finish), .k_results(k_results)
    );
endmodule

// File: rtl/kctl_lite_chk.sv
// Protocol and handshake checker for the kernel control slave, bound to the top.
module kctl_lite_chk #(
    parameter int N_IN = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               s_awvalid,
    input logic               s_awready,
    input logic               s_wvalid,
    input logic               s_wready,
    input logic               s_bvalid,
    input logic               s_bready,
    input logic [1:0]         s_bresp,
    input logic               s_rvalid,
    input logic               s_rready,
    input logic [31:0]        s_rdata,
    input logic [1:0]         s_rresp,
    input logic               k_start,
    input logic [N_IN*32-1:0] k_params
);
    assert_bvalid_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        s_bvalid && !s_bready |=> s_bvalid);

    assert_rvalid_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        s_rvalid && !s_rready |=> s_rvalid && $stable(s_rdata));

    assert_bresp_okay_R6: assert property (@(posedge clk) disable iff (!rst_n)
        s_bvalid |-> s_bresp == 2'b00);

    assert_rresp_okay_R6: assert property (@(posedge clk) disable iff (!rst_n)
        s_rvalid |-> s_rresp == 2'b00);

    assert_start_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        k_start |=> !k_start);

    assert_start_with_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        k_start |-> $rose(s_bvalid));

    assert_params_on_resp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(k_params) |-> $rose(s_bvalid));

    assert_aw_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        s_awvalid && s_awready && !(s_wvalid && s_wready) |=> !s_awready);
endmodule

bind kctl_lite_slave kctl_lite_chk #(.N_IN(N_IN)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .s_awvalid(s_awvalid), .s_awready(s_awready),
    .s_wvalid(s_wvalid), .s_wready(s_wready),
    .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bresp(s_bresp),
    .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rdata(s_rdata), .s_rresp(s_rresp),
    .k_start(k_start), .k_params(k_params)
);

// File: tb/sim_kctl_lite_slave.sv
`timescale 1ns/1ps
module sim_kctl_lite_slave;
    localparam int AW = 8;
    localparam int NI = 3;
    localparam int NO = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] awaddr = '0, araddr = '0;
    logic awvalid = 0, wvalid = 0, bready = 0, arvalid = 0, rready = 0;
    logic [31:0] wdata = '0;
    logic [3:0] wstrb = '0;
    logic awready, wready, bvalid, arready, rvalid, kstart;
    logic [1:0] bresp, rresp;
    logic [31:0] rdata;
    logic [NI*32-1:0] kparams;
    logic kfinish = 0;
    logic [NO*32-1:0] kresults = '0;

    always #4 clk = ~clk;

    kctl_lite_slave #(.ADDR_W(AW), .N_IN(NI), .N_OUT(NO)) u0 (
        .clk(clk), .rst_n(rst_n),
        .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
        .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(wready),
        .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(bready),
        .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready),
        .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(rready),
        .k_start(kstart), .k_params(kparams),
        .k_finish(kfinish), .k_results(kresults)
    );

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;
    int starts_seen = 0;
    int starts_model = 0;

    // Behavioural reference model
    logic [31:0] m_in [NI];
    logic [31:0] m_out [NO];
    int m_state = 0; // 0 idle, 1 running, 2 done

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic void model_reset();
        for (int k = 0; k < NI; k++) m_in[k] = '0;
        for (int j = 0; j < NO; j++) m_out[j] = '0;
        m_state = 0;
    endfunction

    function automatic logic [31:0] model_read(input logic [AW-1:0] a);
        int idx = int'(a[AW-1:2]);
        if (idx == 0) return (m_state == 2) ? 32'h4 : 32'h0;
        if (idx >= 4 && idx < 4 + NI) return m_in[idx-4];
        if (idx >= 4 + NI && idx < 4 + NI + NO) return m_out[idx-4-NI];
        return 32'h0;
    endfunction

    // Returns 1 when the write is a launch
    function automatic bit model_write(input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] s);
        int idx = int'(a[AW-1:2]);
        if (idx == 0) begin
            if (s == 4'hF && d == 32'h1 && m_state != 1) begin
                m_state = 1;
                return 1;
            end
            return 0;
        end
        if (idx >= 4 && idx < 4 + NI) begin
            for (int b = 0; b < 4; b++)
                if (s[b]) m_in[idx-4][8*b +: 8] = d[8*b +: 8];
        end
        return 0;
    endfunction

    // Per-clock comparison of the parameter vector against the model (R4)
    always @(negedge clk) begin
        #1;
        if (rst_n && !finished) begin
            logic [NI*32-1:0] exp_vec;
            for (int k = 0; k < NI; k++) exp_vec[32*k +: 32] = m_in[k];
            compared++;
            if (kparams !== exp_vec) begin
                mismatched++;
                $display("FAIL R4 k_params actual=%h expected=%h", kparams, exp_vec);
            end
        end
    end

    always @(negedge clk) if (rst_n && kstart) starts_seen++;

    // order: 0 together, 1 address first, 2 data first
    task automatic axi_wr(input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] s,
                          input int order, input string req);
        bit aw_done = 0, w_done = 0, aw_hs, w_hs, exp_start;
        @(negedge clk);
        if (order != 2) begin awaddr = a; awvalid = 1; end
        if (order != 1) begin wdata = d; wstrb = s; wvalid = 1; end
        while (!(aw_done && w_done)) begin
            aw_hs = awvalid && awready;
            w_hs  = wvalid && wready;
            @(negedge clk);
            if (aw_hs) begin awvalid = 0; aw_done = 1; end
            if (w_hs) begin wvalid = 0; w_done = 1; end
            if (order == 1 && aw_done && !w_done && !wvalid) begin
                chk({req, " R7 awready low while address held"}, {31'b0, awready}, 32'h0);
                chk({req, " R7 no response before data"}, {31'b0, bvalid}, 32'h0);
                wdata = d; wstrb = s; wvalid = 1;
            end
            if (order == 2 && w_done && !aw_done && !awvalid) begin
                chk({req, " R7 wready low while data held"}, {31'b0, wready}, 32'h0);
                chk({req, " R7 no response before address"}, {31'b0, bvalid}, 32'h0);
                awaddr = a; awvalid = 1;
            end
        end
        while (!bvalid) @(negedge clk);
        exp_start = model_write(a, d, s);
        if (exp_start) starts_model++;
        chk({req, " R2 k_start with response"}, {31'b0, kstart}, {31'b0, exp_start});
        chk({req, " R6 bresp OKAY"}, {30'b0, bresp}, 32'h0);
        @(negedge clk);
        chk({req, " R8 bvalid held"}, {31'b0, bvalid}, 32'h1);
        chk({req, " R2 k_start one cycle"}, {31'b0, kstart}, 32'h0);
        bready = 1;
        @(negedge clk);
        bready = 0;
        chk({req, " R8 bvalid dropped after ready"}, {31'b0, bvalid}, 32'h0);
    endtask

    task automatic axi_rd(input logic [AW-1:0] a, input string req);
        logic [31:0] exp, first;
        @(negedge clk);
        araddr = a; arvalid = 1;
        while (!arready) @(negedge clk);
        exp = model_read(a);
        @(negedge clk);
        arvalid = 0;
        while (!rvalid) @(negedge clk);
        first = rdata;
        @(negedge clk);
        chk({req, " R8 rvalid held"}, {31'b0, rvalid}, 32'h1);
        chk({req, " R8 rdata stable"}, rdata, first);
        chk({req, " R6 rresp OKAY"}, {30'b0, rresp}, 32'h0);
        chk(req, rdata, exp);
        rready = 1;
        @(negedge clk);
        rready = 0;
    endtask

    task automatic kfin(input logic [31:0] r0, input logic [31:0] r1);
        @(negedge clk);
        kresults = {r1, r0};
        kfinish = 1;
        @(negedge clk);
        kfinish = 0;
        kresults = '0;
        if (m_state == 1) begin
            m_out[0] = r0; m_out[1] = r1; m_state = 2;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            mismatched++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R9 bvalid after reset", {31'b0, bvalid}, 32'h0);
        chk("R9 rvalid after reset", {31'b0, rvalid}, 32'h0);
        chk("R9 k_start after reset", {31'b0, kstart}, 32'h0);
        axi_rd(8'h00, "R9 control idle");
        axi_rd(8'h10, "R9 param0 zero");
        axi_rd(8'h1C, "R9 result0 zero");

        axi_wr(8'h10, 32'h1111_1111, 4'hF, 0, "R4 param0 together");
        axi_wr(8'h14, 32'hA5A5_A5A5, 4'hF, 1, "R7 param1 address first");
        axi_wr(8'h18, 32'h1234_5678, 4'hF, 2, "R7 param2 data first");
        axi_rd(8'h10, "R4 param0 readback");
        axi_rd(8'h14, "R4 param1 readback");
        axi_rd(8'h18, "R1 param2 readback");
        axi_wr(8'h14, 32'hFFFF_FFFF, 4'b0101, 0, "R4 partial strobe");
        axi_rd(8'h14, "R4 partial strobe readback");
        axi_rd(8'h12, "R1 low address bits ignored");

        axi_wr(8'h1C, 32'hDEAD_BEEF, 4'hF, 0, "R5 result write");
        axi_rd(8'h1C, "R5 result unchanged");
        axi_wr(8'h04, 32'hDEAD_BEEF, 4'hF, 0, "R5 unmapped write");
        axi_wr(8'h00, 32'h0000_0002, 4'hF, 0, "R5 control other value");
        axi_wr(8'h00, 32'h0000_0001, 4'h1, 0, "R5 control partial strobe");
        axi_rd(8'h00, "R5 control still idle");
        axi_rd(8'h04, "R6 gap read");
        axi_rd(8'h24, "R6 past results read");
        axi_rd(8'hFC, "R6 top word read");

        kfin(32'h5555_5555, 32'h6666_6666);
        axi_rd(8'h1C, "R10 finish idle ignored");
        axi_rd(8'h00, "R10 control idle after stray finish");

        axi_wr(8'h00, 32'h0000_0001, 4'hF, 0, "R2 launch");
        axi_rd(8'h00, "R2 control reads zero while running");
        axi_wr(8'h00, 32'h0000_0001, 4'hF, 1, "R10 launch while running");
        kfin(32'h0BAD_C0DE, 32'hCAFE_F00D);
        axi_rd(8'h00, "R3 control done");
        axi_rd(8'h1C, "R3 result0");
        axi_rd(8'h20, "R3 result1");
        kfin(32'h7777_7777, 32'h8888_8888);
        axi_rd(8'h1C, "R10 finish while done ignored");
        axi_rd(8'h00, "R3 done persists");

        axi_wr(8'h00, 32'h0000_0001, 4'hF, 2, "R2 relaunch from done");
        axi_rd(8'h00, "R2 control cleared on relaunch");
        kfin(32'h0000_0042, 32'hFFFF_0000);
        axi_rd(8'h20, "R3 second result1");
        axi_rd(8'h00, "R3 second done");

        axi_wr(8'h00, 32'h0000_0001, 4'hF, 0, "R2 launch before reset");
        do_reset();
        @(negedge clk);
        chk("R9 k_start low after reset", {31'b0, kstart}, 32'h0);
        axi_rd(8'h00, "R9 control idle after reset");
        axi_rd(8'h10, "R9 param0 cleared");
        axi_rd(8'h20, "R9 result1 cleared");

        chk("R2 launch pulse count", starts_seen, starts_model);
        finished = 1;
        summary();
        $finish;
    end
endmodule